// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block moves bytes over the single bidirectional data wire of a contact smart card. Bytes offered on a transmit stream are framed as a low start bit, eight data bits and a parity bit. Each bit lasts one elementary time unit (etu), which is a programmable number of clock cycles. The wire is open-drain, so the block only ever pulls it low (`io_oe`) and reads it back on `io_in`. Received characters are sampled in the middle of each bit and handed to a receive stream. The same conventions set three things in both directions: which end of the byte goes first, whether a high wire means logical 1 or logical 0, and whether parity is even or odd.

The wire is half duplex. A receiver that finds bad parity pulls the wire low in the window from 10.5 to 11.5 etu after the start edge. The transmitter reads the wire at 11 etu. If it finds that error signal, it resends the same byte a limited number of times. Each direction has its own retry limit. A guard gap follows every transmitted frame. A turnaround gap separates the end of a received character from the next transmission. A loopback mode routes the block's own drive into its receiver, and a force control holds the wire low.

Transmit stream: a byte moves when `tx_valid` and `tx_ready` are both high at a clock edge. `tx_ready` is high only while the transmitter is idle and no character is arriving. The producer may hold `tx_valid` for as long as it likes. Receive stream: `rx_valid` and `rx_data` stay unchanged until `rx_ready` is seen high, and `rx_valid` drops in the next cycle. The wire itself cannot be stalled. A character that completes while the previous one has not been taken replaces it.

Top module: `sc_char_xcvr`

## Requirements
- R1: A transmitted frame begins with `io_oe` high for one etu (start bit). Eight data bits follow, then one parity bit, then two released etus, giving 12 etus in all. One etu equals `cfg_tx_div` cycles. With `cfg_lsb_first`=1 data bit 0 goes first; with 0, bit 7 goes first.
- R2: With `cfg_inverse`=0 a high wire carries logical 1. With 1 a high wire carries logical 0. This applies to data and parity in both directions, and the bit is sent as `io_oe` = NOT(wire level).
- R3: The parity bit makes the count of ones over data plus parity even when `cfg_odd_parity`=0, and odd when it is 1.
- R4: The receiver detects a falling wire, samples at mid-etu (etu = `cfg_rx_div` cycles) and rebuilds the byte under the same order and polarity settings. A byte with good parity appears on `rx_data` with `rx_valid`, held until `rx_ready`.
- R5: A received character with bad parity pulses `rx_parity_err` for one cycle and is never delivered. While retries remain, `io_oe` is high from about 10.5 to 11.5 etu after its start edge.
- R6: The receiver sends the error signal for at most `cfg_rx_retry` consecutive bad characters. The next bad one is not signalled and the count restarts. A good character also restarts it.
- R7: If the wire is low at 11 etu of a transmitted frame, `tx_parity_err` pulses and the same byte is resent. A byte is sent at most `cfg_tx_retry`+1 times and is then dropped.
- R8: The start of a following frame comes `(12+cfg_guard)*cfg_tx_div` cycles after the previous start when it is a resend, and one cycle later when it is a new byte taken from the stream.
- R9: After a received character finishes, no transmission starts for `cfg_turnaround` etus.
- R10: Outside loopback, `tx_ready` is low while a character is being received, and the receiver ignores the wire while a frame is being transmitted.
- R11: In loopback the receiver sees the transmitter's own drive, and `io_oe` stays low unless forced.
- R12: While `cfg_force_low` is 1, `io_oe` is high.
- R13: After reset `tx_ready` is high, while `rx_valid` and `io_oe` are low. `tx_ready` drops in the cycle after a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lsb_first | input | 1 | 1: bit 0 first, 0: bit 7 first |
| cfg_inverse | input | 1 | 1: high wire means logical 0 |
| cfg_odd_parity | input | 1 | 0: even parity, 1: odd parity |
| cfg_loopback | input | 1 | Route own drive into receiver, pad released |
| cfg_force_low | input | 1 | Hold the wire low |
| cfg_rx_div | input | DIV_W | Receive cycles per etu (at least 4) |
| cfg_tx_div | input | DIV_W | Transmit cycles per etu (at least 4) |
| cfg_rx_retry | input | RETRY_W | Receive error-signal limit |
| cfg_tx_retry | input | RETRY_W | Transmit resend limit |
| cfg_guard | input | GAP_W | Extra etus after each transmitted frame |
| cfg_turnaround | input | GAP_W | Etus between a received character and the next transmission |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the byte |
| rx_data | output | 8 | Received byte |
| rx_parity_err | output | 1 | One-cycle pulse per bad received character |
| tx_parity_err | output | 1 | One-cycle pulse per error signal seen on transmit |
| io_in | input | 1 | Wire level |
| io_oe | output | 1 | 1 pulls the wire low |

## Verification
Every timed result follows from the etu: transmit bits change each `cfg_tx_div` cycles from the cycle after the transfer, so the bench finds the first cycle with `io_oe` high and samples each bit half an etu later. Received bytes become valid about 11.5 etu plus one cycle after the card's start edge, so the bench checks them at 12 etu. Error-signal levels are checked at 11 etu, the middle of their window. The frame-to-frame spacing is measured exactly, at (12+guard)·div+1 cycles. The turnaround delay is measured against 11.5 etu + 2 + turnaround·div cycles, with one cycle of slack for start-edge sampling.

// File: rtl/scx_pkg.sv
package scx_pkg;
  localparam int BYTE_W = 8;
  localparam int FRAME_ETUS = 12;

  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_GAP} tx_state_e;
  typedef enum logic {RX_IDLE, RX_RECV} rx_state_e;

  // parity bit that completes the requested sense
  function automatic logic parity_of(input logic [BYTE_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // logical value of data position k (1..8) in sending order
  function automatic logic pick_bit(input logic [BYTE_W-1:0] d, input logic [3:0] k,
                                    input logic lsb_first);
    logic [3:0] i;
    i = lsb_first ? (k - 4'd1) : (4'd8 - k);
    return d[i[2:0]];
  endfunction
endpackage

// File: rtl/scx_tx.sv
module scx_tx
  import scx_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int RETRY_W = 4,
  parameter int GAP_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   div,
  input  logic [GAP_W-1:0]   guard,
  input  logic [GAP_W-1:0]   turnaround,
  input  logic               lsb_first,
  input  logic               inverse,
  input  logic               odd_parity,
  input  logic [RETRY_W-1:0] retry_lim,
  input  logic               line,
  input  logic               hold_off,
  input  logic               rx_done_tn,
  input  logic               in_valid,
  input  logic [BYTE_W-1:0]  in_data,
  output logic               in_ready,
  output logic               drive_low,
  output logic               sending,
  output logic               err_pulse
);
  localparam logic [3:0] LAST_ETU = 4'(FRAME_ETUS - 1);

  tx_state_e          st;
  logic [DIV_W-1:0]   cyc;
  logic [3:0]         etu;
  logic [GAP_W-1:0]   gap_left;
  logic [BYTE_W-1:0]  byte_q;
  logic [RETRY_W-1:0] tries;
  logic               err_seen, resend;
  logic               etu_end, want_resend, data_bit;

  assign etu_end     = (cyc == div - DIV_W'(1));
  assign want_resend = err_seen && (tries < retry_lim);
  assign in_ready    = (st == TX_IDLE) && !hold_off && !rx_done_tn;
  assign sending     = (st == TX_SEND);

  always_comb begin
    data_bit = 1'b0;
    if (etu >= 4'd1 && etu <= 4'd8) data_bit = pick_bit(byte_q, etu, lsb_first);
    else if (etu == 4'd9)           data_bit = parity_of(byte_q, odd_parity);
  end

  // start bit always low; data level = logical bit xor inverse
  assign drive_low = sending && ((etu == 4'd0) || (etu <= 4'd9 && !(data_bit ^ inverse)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= TX_IDLE; cyc <= '0; etu <= '0; gap_left <= '0; byte_q <= '0;
      tries <= '0; err_seen <= 1'b0; resend <= 1'b0; err_pulse <= 1'b0;
    end else begin
      err_pulse <= 1'b0;
      case (st)
        TX_IDLE: begin
          if (in_valid && in_ready) begin
            byte_q <= in_data; tries <= '0; err_seen <= 1'b0;
            cyc <= '0; etu <= '0; st <= TX_SEND;
          end else if (rx_done_tn && turnaround != '0) begin
            gap_left <= turnaround; cyc <= '0; resend <= 1'b0; st <= TX_GAP;
          end
        end
        TX_SEND: begin
          if (etu == LAST_ETU && cyc == '0 && !line) begin
            err_seen <= 1'b1; err_pulse <= 1'b1;
          end
          if (!etu_end) cyc <= cyc + DIV_W'(1);
          else begin
            cyc <= '0;
            if (etu != LAST_ETU) etu <= etu + 4'd1;
            else begin
              resend <= want_resend;
              if (want_resend) tries <= tries + RETRY_W'(1);
              if (guard != '0) begin
                gap_left <= guard; st <= TX_GAP;
              end else if (want_resend) begin
                etu <= '0; err_seen <= 1'b0;
              end else st <= TX_IDLE;
            end
          end
        end
        default: begin
          if (!etu_end) cyc <= cyc + DIV_W'(1);
          else begin
            cyc <= '0;
            if (gap_left != GAP_W'(1)) gap_left <= gap_left - GAP_W'(1);
            else if (resend) begin
              etu <= '0; err_seen <= 1'b0; st <= TX_SEND;
            end else st <= TX_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/scx_rx.sv
module scx_rx
  import scx_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   div,
  input  logic               lsb_first,
  input  logic               inverse,
  input  logic               odd_parity,
  input  logic [RETRY_W-1:0] retry_lim,
  input  logic               enable,
  input  logic               line,
  output logic               busy,
  output logic               drive_low,
  output logic               deliver,
  output logic [BYTE_W-1:0]  data,
  output logic               err_pulse,
  output logic               done
);
  rx_state_e          st;
  logic [DIV_W-1:0]   cyc;
  logic [3:0]         etu;
  logic [BYTE_W-1:0]  sh;
  logic [RETRY_W-1:0] errs;
  logic               bad, signal_err;
  logic [DIV_W-1:0]   half;
  logic               mid, bitv;

  assign half = div >> 1;
  assign mid  = (cyc == half);
  assign bitv = line ^ inverse;
  assign busy = (st == RX_RECV);
  assign data = sh;
  assign drive_low = busy && signal_err &&
                     ((etu == 4'd10 && cyc >= half) || (etu == 4'd11 && cyc < half));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE; cyc <= '0; etu <= '0; sh <= '0; errs <= '0;
      bad <= 1'b0; signal_err <= 1'b0; deliver <= 1'b0; err_pulse <= 1'b0; done <= 1'b0;
    end else begin
      deliver <= 1'b0; err_pulse <= 1'b0; done <= 1'b0;
      if (st == RX_IDLE) begin
        if (enable && !line) begin
          st <= RX_RECV; cyc <= DIV_W'(1); etu <= '0; bad <= 1'b0; signal_err <= 1'b0;
        end
      end else begin
        if (cyc == div - DIV_W'(1)) begin
          cyc <= '0; etu <= etu + 4'd1;
        end else cyc <= cyc + DIV_W'(1);
        if (mid) begin
          if (etu == 4'd0) begin
            if (line) st <= RX_IDLE;                 // false start
          end else if (etu <= 4'd8) begin
            sh <= lsb_first ? {bitv, sh[7:1]} : {sh[6:0], bitv};
          end else if (etu == 4'd9) begin
            if (bitv != parity_of(sh, odd_parity)) begin
              bad <= 1'b1; err_pulse <= 1'b1;
              if (errs < retry_lim) begin
                signal_err <= 1'b1; errs <= errs + RETRY_W'(1);
              end else errs <= '0;
            end else errs <= '0;
          end else if (etu == 4'd11) begin
            st <= RX_IDLE; done <= 1'b1; deliver <= !bad;
          end
        end
      end
    end
  end
endmodule

// File: rtl/scx_hold.sv
module scx_hold
  import scx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_data <= '0;
    end else if (load) begin
      out_valid <= 1'b1; out_data <= load_data;     // newest character wins
    end else if (out_ready) out_valid <= 1'b0;
  end
endmodule

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr
  import scx_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int RETRY_W = 4,
  parameter int GAP_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_lsb_first,
  input  logic               cfg_inverse,
  input  logic               cfg_odd_parity,
  input  logic               cfg_loopback,
  input  logic               cfg_force_low,
  input  logic [DIV_W-1:0]   cfg_rx_div,
  input  logic [DIV_W-1:0]   cfg_tx_div,
  input  logic [RETRY_W-1:0] cfg_rx_retry,
  input  logic [RETRY_W-1:0] cfg_tx_retry,
  input  logic [GAP_W-1:0]   cfg_guard,
  input  logic [GAP_W-1:0]   cfg_turnaround,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [7:0]         tx_data,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic [7:0]         rx_data,
  output logic               rx_parity_err,
  output logic               tx_parity_err,
  input  logic               io_in,
  output logic               io_oe
);
  logic tx_drive, rx_drive, tx_sending, rx_busy, rx_done, rx_deliver, line;
  logic [BYTE_W-1:0] rx_byte;

  assign line  = cfg_loopback ? ~(tx_drive | rx_drive | cfg_force_low) : io_in;
  assign io_oe = cfg_force_low | (~cfg_loopback & (tx_drive | rx_drive));

  scx_tx #(.DIV_W(DIV_W), .RETRY_W(RETRY_W), .GAP_W(GAP_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .div(cfg_tx_div), .guard(cfg_guard),
    .turnaround(cfg_turnaround), .lsb_first(cfg_lsb_first), .inverse(cfg_inverse),
    .odd_parity(cfg_odd_parity), .retry_lim(cfg_tx_retry), .line(line),
    .hold_off(rx_busy & ~cfg_loopback), .rx_done_tn(rx_done & ~cfg_loopback),
    .in_valid(tx_valid), .in_data(tx_data), .in_ready(tx_ready),
    .drive_low(tx_drive), .sending(tx_sending), .err_pulse(tx_parity_err));

  scx_rx #(.DIV_W(DIV_W), .RETRY_W(RETRY_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .div(cfg_rx_div), .lsb_first(cfg_lsb_first),
    .inverse(cfg_inverse), .odd_parity(cfg_odd_parity), .retry_lim(cfg_rx_retry),
    .enable(cfg_loopback | ~tx_sending), .line(line), .busy(rx_busy),
    .drive_low(rx_drive), .deliver(rx_deliver), .data(rx_byte),
    .err_pulse(rx_parity_err), .done(rx_done));

  scx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .load(rx_deliver), .load_data(rx_byte),
    .out_valid(rx_valid), .out_data(rx_data), .out_ready(rx_ready));
endmodule

// File: rtl/scx_checker.sv
module scx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_loopback,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       rx_deliver,
  input logic       rx_busy,
  input logic       rx_parity_err,
  input logic       tx_parity_err
);
  a_r13_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);
  a_r4_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid);
  a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready && !rx_deliver |=> $stable(rx_data));
  a_r10_no_tx_during_rx: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_loopback && rx_busy |-> !tx_ready);
  a_r5_rx_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_parity_err |=> !rx_parity_err);
  a_r7_tx_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_parity_err |=> !tx_parity_err);
endmodule

bind sc_char_xcvr scx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_loopback(cfg_loopback),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data), .rx_deliver(rx_deliver),
  .rx_busy(rx_busy), .rx_parity_err(rx_parity_err), .tx_parity_err(tx_parity_err));

// File: tb/sc_char_xcvr_bench.sv
module sc_char_xcvr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int D = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lsb = 1'b1, inv = 1'b0, odd = 1'b0, loopb = 1'b0, force_lo = 1'b0;
  logic [3:0] rx_lim = 4'd3, tx_lim = 4'd3;
  logic [7:0] guard = 8'd0, ta = 8'd0;
  logic tx_valid = 1'b0, rx_ready = 1'b0, card_pull = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_ready, rx_valid, rx_perr, tx_perr, io_oe, io_in;
  logic [7:0] rx_data;
  int checks = 0, errors = 0, cyc_cnt = 0, rxp_cnt = 0, txp_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;
  always @(negedge clk) begin
    if (rst_n && rx_perr) rxp_cnt++;
    if (rst_n && tx_perr) txp_cnt++;
  end
  assign io_in = ~(io_oe | card_pull);

  sc_char_xcvr u_sc_char_xcvr (
    .clk(clk), .rst_n(rst_n), .cfg_lsb_first(lsb), .cfg_inverse(inv),
    .cfg_odd_parity(odd), .cfg_loopback(loopb), .cfg_force_low(force_lo),
    .cfg_rx_div(12'(D)), .cfg_tx_div(12'(D)), .cfg_rx_retry(rx_lim),
    .cfg_tx_retry(tx_lim), .cfg_guard(guard), .cfg_turnaround(ta),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_parity_err(rx_perr), .tx_parity_err(tx_perr), .io_in(io_in), .io_oe(io_oe));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // wire level (1 = high) for frame bit k (0 start, 1..8 data, 9 parity)
  function automatic logic level_of(input logic [7:0] b, input int k, input bit bad);
    int ones = 0;
    logic v;
    for (int i = 0; i < 8; i++) ones += b[i];
    if (k == 0) return 1'b0;
    if (k <= 8) v = lsb ? b[k-1] : b[8-k];
    else v = ((ones % 2) != 0) ^ odd ^ bad;
    return v ^ inv;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    tx_data = b; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic card_send(input logic [7:0] b, input bit bad);
    for (int k = 0; k < 10; k++) begin
      card_pull = ~level_of(b, k, bad);
      cycles(D);
    end
    card_pull = 1'b0;
  endtask

  task automatic pop_rx();
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic t_reset();
    check(tx_ready == 1'b1, "R13 ready after reset", tx_ready, 1);
    check(rx_valid == 1'b0 && io_oe == 1'b0, "R13 idle after reset", rx_valid + io_oe, 0);
  endtask

  task automatic t_tx_frame(input logic [7:0] b, input bit l, input bit iv, input bit od,
                            input string req);
    int miss = 0;
    lsb = l; inv = iv; odd = od;
    send_byte(b);
    check(tx_ready == 1'b0, "R13 ready drops", tx_ready, 0);
    cycles(D/2);
    for (int k = 0; k < 12; k++) begin
      logic e;
      e = (k < 10) ? ~level_of(b, k, 0) : 1'b0;
      if (io_oe !== e) miss++;
      if (k < 11) cycles(D);
    end
    check(miss == 0, req, miss, 0);
    cycles(D/2 + 2);
    check(rx_valid == 1'b0, "R10 receiver ignores own frame", rx_valid, 0);
  endtask

  task automatic t_guard(input logic [7:0] g);
    int c1, c2, exp;
    guard = g;
    send_byte(8'h11); c1 = cyc_cnt;
    send_byte(8'h22); c2 = cyc_cnt;
    exp = (12 + g) * D + 1;
    check(c2 - c1 == exp, "R8 frame spacing", c2 - c1, exp);
    cycles(12 * D + g * D + 2);
    guard = 0;
  endtask

  task automatic t_rx(input logic [7:0] b, input bit l, input bit iv, input bit od,
                      input string req);
    int p0 = rxp_cnt;
    lsb = l; inv = iv; odd = od;
    card_send(b, 0);
    cycles(D);
    check(io_oe == 1'b0, "R5 no error signal on good parity", io_oe, 0);
    cycles(D);
    check(rx_valid == 1'b1 && rx_data == b, req, rx_data, b);
    check(rxp_cnt == p0, "R5 no parity pulse", rxp_cnt - p0, 0);
    cycles(3);
    check(rx_valid == 1'b1, "R4 held without ready", rx_valid, 1);
    pop_rx();
    check(rx_valid == 1'b0, "R4 taken after ready", rx_valid, 0);
    cycles(2 * D);
  endtask

  task automatic t_rx_bad();
    int p0 = rxp_cnt;
    rx_lim = 4'd2; lsb = 1; inv = 0; odd = 0;
    for (int i = 0; i < 3; i++) begin
      card_send(8'h6B, 1);
      cycles(D);
      check(io_oe == (i < 2), (i < 2) ? "R5 error signal" : "R6 limit reached, no signal",
            io_oe, i < 2);
      cycles(3 * D);
      check(rx_valid == 1'b0, "R5 bad byte not delivered", rx_valid, 0);
    end
    check(rxp_cnt - p0 == 3, "R5 parity pulses", rxp_cnt - p0, 3);
    card_send(8'h6B, 1);
    cycles(D);
    check(io_oe == 1'b1, "R6 count restarted", io_oe, 1);
    cycles(3 * D);
    rx_lim = 4'd3;
  endtask

  task automatic t_tx_retry();
    int p0 = txp_cnt;
    tx_lim = 4'd2; lsb = 1; inv = 0; odd = 0;
    send_byte(8'h5A);
    for (int i = 0; i < 3; i++) begin
      cycles(10 * D + D/2);
      card_pull = 1'b1;
      cycles(D);
      card_pull = 1'b0;
      cycles(D/2);
      check(io_oe == (i < 2), (i < 2) ? "R7 resend starts" : "R7 dropped after limit",
            io_oe, i < 2);
    end
    cycles(13 * D);
    check(txp_cnt - p0 == 3, "R7 error pulses", txp_cnt - p0, 3);
    check(tx_ready == 1'b1, "R7 ready after drop", tx_ready, 1);
    tx_lim = 4'd3;
  endtask

  task automatic t_turn();
    int c0 = 0, c1 = 0, exp;
    ta = 8'd4; lsb = 1; inv = 0; odd = 0;
    @(negedge clk);
    fork
      begin c0 = cyc_cnt; card_send(8'h9C, 0); end
      begin
        cycles(2 * D);
        check(tx_ready == 1'b0, "R10 no tx during rx", tx_ready, 0);
        send_byte(8'h44); c1 = cyc_cnt;
      end
    join
    exp = 11 * D + D/2 + 2 + 4 * D;
    check(c1 - c0 >= exp - 1 && c1 - c0 <= exp + 1, "R9 turnaround delay", c1 - c0, exp);
    check(rx_valid == 1'b1 && rx_data == 8'h9C, "R4 byte before turnaround", rx_data, 8'h9C);
    pop_rx();
    cycles(13 * D);
    ta = 8'd0;
  endtask

  task automatic t_loop();
    int seen = 0;
    loopb = 1'b1; lsb = 0; inv = 1; odd = 1;
    send_byte(8'hC3);
    for (int i = 0; i < 13 * D; i++) begin
      if (io_oe) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R11 pad quiet in loopback", seen, 0);
    check(rx_valid == 1'b1 && rx_data == 8'hC3, "R11 own byte received", rx_data, 8'hC3);
    pop_rx();
    loopb = 1'b0;
    cycles(2 * D);
  endtask

  task automatic t_force();
    force_lo = 1'b1;
    @(negedge clk);
    check(io_oe == 1'b1, "R12 forced low", io_oe, 1);
    force_lo = 1'b0;
    @(negedge clk);
    check(io_oe == 1'b0, "R12 released", io_oe, 0);
    cycles(2 * D);
    check(rx_valid == 1'b0, "R4 short pulse not a character", rx_valid, 0);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_tx_frame(8'hA5, 1, 0, 0, "R1 R3 lsb-first even frame");
    t_tx_frame(8'hA5, 0, 0, 1, "R1 R3 msb-first odd frame");
    t_tx_frame(8'h3C, 0, 1, 0, "R2 inverted frame");
    t_guard(8'd0);
    t_guard(8'd3);
    t_rx(8'hB2, 1, 0, 0, "R4 receive direct");
    t_rx(8'h3B, 0, 1, 1, "R2 R3 R4 receive inverse odd");
    t_rx_bad();
    t_tx_retry();
    t_turn();
    t_loop();
    t_force();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule